// File: doc/BRIEF.md
# Dual-Unit Request Holding Buffer

This block sits between an issue port and two execution units, one that handles loads and one that handles stores. Each incoming memory request carries an address, a store operand, byte enables, a unit selector, an operation code and a transaction tag. The block presents one request at a time to both units and holds it steady until the unit it targets removes it with a pop.

A request that cannot be consumed in the cycle it arrives goes into a small FIFO of `DEPTH` entries, which is two by default. Upstream readiness falls when every entry is occupied. When the FIFO is empty and the targeted unit reports ready, a new request is shown to the units in the same cycle. If that unit also pops it in that cycle, the request never occupies storage.

Top module: `req_hold_buf`

## Requirements
- R1: An active-low asynchronous reset empties the FIFO. While reset is held and no request is offered, `outValid` is 0 and `reqReady` is 1.
- R2: With the FIFO empty, an offered request whose target unit's ready input is 1 appears on the outputs in the same cycle, with `outValid` at 1.
- R3: A request that is offered while `reqReady` is 1 and not popped in that cycle is stored, and it is presented in a later cycle with every field intact.
- R4: `reqReady` is 0 exactly when `DEPTH` requests are stored.
- R5: While the presented request is not popped by its matching unit, the next cycle presents the same request with `outValid` still 1.
- R6: A pop from the matching unit removes the presented request, and stored requests leave in arrival order.
- R7: A pop from the unit that does not match `outUnit` is ignored, and so is any pop while `outValid` is 0.
- R8: `reqUnit`/`outUnit` value 0 selects the load unit (`loadReady`, `loadPop`) and value 1 selects the store unit (`storeReady`, `storePop`).
- R9: With the FIFO empty, if the target unit is not ready then `outValid` stays 0 in the arrival cycle and the request is presented from storage in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Incoming request valid |
| reqAddr | input | ADDR_W (16) | Virtual address |
| reqOperand | input | DATA_W (32) | Store operand |
| reqByteEn | input | DATA_W/8 (4) | Byte enables |
| reqUnit | input | 1 | Target unit: 0 load, 1 store |
| reqOpcode | input | OP_W (4) | Operation code |
| reqTag | input | TAG_W (3) | Transaction tag |
| loadReady | input | 1 | Load unit ready |
| storeReady | input | 1 | Store unit ready |
| loadPop | input | 1 | Load unit removes the presented request |
| storePop | input | 1 | Store unit removes the presented request |
| reqReady | output | 1 | Buffer can accept a request |
| outValid | output | 1 | Presented request valid |
| outAddr | output | ADDR_W | Presented address |
| outOperand | output | DATA_W | Presented operand |
| outByteEn | output | DATA_W/8 | Presented byte enables |
| outUnit | output | 1 | Presented target unit |
| outOpcode | output | OP_W | Presented operation code |
| outTag | output | TAG_W | Presented tag |

## Verification
The bench builds the block with its default `DEPTH` of 2 and the package widths (16-bit address, 32-bit operand). A depth of two lets a few requests fill the FIFO, turn upstream readiness off and wrap the read and write pointers several times within a short sequence. The full state also brings a simultaneous pop and push, and a pop from the wrong unit on a waiting head, within a handful of cycles. Each presented record is checked field by field against values that the bench derives from its address.

// File: rtl/rqb_pkg.sv
package rqb_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int OP_W   = 4;
  localparam int TAG_W  = 3;

  typedef enum logic {UNIT_LOAD = 1'b0, UNIT_STORE = 1'b1} unit_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] operand;
    logic [BE_W-1:0]   byteEn;
    unit_e             unit;
    logic [OP_W-1:0]   opcode;
    logic [TAG_W-1:0]  tag;
  } req_rec_t;

  // control -> datapath strobes
  typedef struct packed {
    logic push;    // write incoming request into the FIFO
    logic fifoPop; // retire the FIFO head
    logic bypass;  // present the incoming request directly
  } rqb_strobe_t;
endpackage

// File: rtl/rqb_ctrl.sv
module rqb_ctrl
  import rqb_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  unit_e       reqUnit,
  input  logic        loadReady,
  input  logic        storeReady,
  input  logic        loadPop,
  input  logic        storePop,
  input  unit_e       headUnit,
  output rqb_strobe_t strobe,
  output logic        reqReady,
  output logic        outValid
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          fifoEmpty;
  logic          unitReady;
  logic          popHit;

  assign fifoEmpty = (count == '0);
  assign reqReady  = (count != CW'(DEPTH));
  assign unitReady = (reqUnit == UNIT_STORE) ? storeReady : loadReady;

  always_comb begin
    strobe.bypass = fifoEmpty && reqValid && unitReady;
    outValid      = !fifoEmpty || strobe.bypass;
    popHit        = outValid && ((headUnit == UNIT_STORE) ? storePop : loadPop);
    // a bypassed request that is popped at once never occupies storage
    strobe.push    = reqValid && reqReady && !(strobe.bypass && popHit);
    strobe.fifoPop = popHit && !strobe.bypass;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      count <= count + CW'(strobe.push) - CW'(strobe.fifoPop);
    end
  end
endmodule

// File: rtl/rqb_store.sv
module rqb_store
  import rqb_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  rqb_strobe_t strobe,
  input  req_rec_t    inRec,
  output req_rec_t    outRec
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  req_rec_t        slots [DEPTH];
  logic [PW-1:0]   wrPtr;
  logic [PW-1:0]   rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign outRec = strobe.bypass ? inRec : slots[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push)    wrPtr <= nextPtr(wrPtr);
      if (strobe.fifoPop) rdPtr <= nextPtr(rdPtr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.push && (wrPtr == PW'(i))) slots[i] <= inRec;
    end
  end
endmodule

// File: rtl/req_hold_buf.sv
module req_hold_buf
  import rqb_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqOperand,
  input  logic [BE_W-1:0]   reqByteEn,
  input  logic              reqUnit,
  input  logic [OP_W-1:0]   reqOpcode,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic              loadReady,
  input  logic              storeReady,
  input  logic              loadPop,
  input  logic              storePop,
  output logic              reqReady,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outOperand,
  output logic [BE_W-1:0]   outByteEn,
  output logic              outUnit,
  output logic [OP_W-1:0]   outOpcode,
  output logic [TAG_W-1:0]  outTag
);
  req_rec_t    inRec;
  req_rec_t    outRec;
  rqb_strobe_t strobe;

  assign inRec = '{addr: reqAddr, operand: reqOperand, byteEn: reqByteEn,
                   unit: unit_e'(reqUnit), opcode: reqOpcode, tag: reqTag};

  rqb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqUnit    (unit_e'(reqUnit)),
    .loadReady  (loadReady),
    .storeReady (storeReady),
    .loadPop    (loadPop),
    .storePop   (storePop),
    .headUnit   (outRec.unit),
    .strobe     (strobe),
    .reqReady   (reqReady),
    .outValid   (outValid)
  );

  rqb_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inRec  (inRec),
    .outRec (outRec)
  );

  assign outAddr    = outRec.addr;
  assign outOperand = outRec.operand;
  assign outByteEn  = outRec.byteEn;
  assign outUnit    = outRec.unit;
  assign outOpcode  = outRec.opcode;
  assign outTag     = outRec.tag;
endmodule

// File: rtl/rqb_checker.sv
module rqb_checker
  import rqb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              loadPop,
  input logic              storePop,
  input logic              reqReady,
  input logic              outValid,
  input logic              outUnit,
  input logic [ADDR_W-1:0] outAddr,
  input logic [TAG_W-1:0]  outTag
);
  logic matchPop;
  assign matchPop = outUnit ? storePop : loadPop;

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_ready_R1: assert (reqReady);
    end
  end

  // R4: a full FIFO always has a head to present
  assert_full_has_head_R4: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> outValid);

  // R5 / R7: an unpopped request is held unchanged
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !matchPop) |=> (outValid && $stable(outAddr) && $stable(outTag) && $stable(outUnit)));

  // R6: a matching pop on a full FIFO frees a slot
  assert_pop_frees_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && matchPop) |=> reqReady);
endmodule

bind req_hold_buf rqb_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadPop  (loadPop),
  .storePop (storePop),
  .reqReady (reqReady),
  .outValid (outValid),
  .outUnit  (outUnit),
  .outAddr  (outAddr),
  .outTag   (outTag)
);

// File: tb/sim_req_hold_buf.sv
`timescale 1ns/1ps
module sim_req_hold_buf;
  import rqb_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqOperand;
  logic [BE_W-1:0]   reqByteEn;
  logic              reqUnit = 1'b0;
  logic [OP_W-1:0]   reqOpcode;
  logic [TAG_W-1:0]  reqTag;
  logic              loadReady = 1'b0, storeReady = 1'b0;
  logic              loadPop = 1'b0, storePop = 1'b0;
  logic              reqReady, outValid, outUnit;
  logic [ADDR_W-1:0] outAddr;
  logic [DATA_W-1:0] outOperand;
  logic [BE_W-1:0]   outByteEn;
  logic [OP_W-1:0]   outOpcode;
  logic [TAG_W-1:0]  outTag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // other fields are derived from the address
  assign reqOperand = {reqAddr, ~reqAddr};
  assign reqByteEn  = reqAddr[3:0];
  assign reqOpcode  = reqAddr[3:0] ^ 4'h5;
  assign reqTag     = reqAddr[2:0];

  req_hold_buf u0 (.*);

  typedef struct packed {
    logic       v;
    logic       unit;
    logic [7:0] addr;
    logic       lr, sr, lp, sp;
    logic       expV;
    logic       expU;
    logic [7:0] expA;
    logic       expRdy;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1,0,8'h11, 1,0,1,0, 1,0,8'h11,1, 4'd2}, // R2 pass-through, popped at once
    '{1,1,8'h22, 0,0,0,0, 0,0,8'h00,1, 4'd9}, // R9 store not ready
    '{1,0,8'h33, 1,0,0,0, 1,1,8'h22,1, 4'd3}, // R3 head from storage, second push
    '{0,0,8'h00, 0,0,1,0, 1,1,8'h22,0, 4'd4}, // R4 full; R7 load pop on store head
    '{0,0,8'h00, 0,0,0,1, 1,1,8'h22,0, 4'd6}, // R6 store pop
    '{1,1,8'h44, 0,0,1,0, 1,0,8'h33,1, 4'd6}, // R6 order, pop with push
    '{0,0,8'h00, 0,0,0,0, 1,1,8'h44,1, 4'd5}, // R5 held
    '{0,0,8'h00, 0,0,0,1, 1,1,8'h44,1, 4'd5}, // R5 still same, popped
    '{0,0,8'h00, 0,0,0,0, 0,0,8'h00,1, 4'd6}, // R6 drained
    '{1,1,8'h55, 0,1,0,0, 1,1,8'h55,1, 4'd8}, // R8 store ready steers bypass
    '{0,0,8'h00, 0,1,0,1, 1,1,8'h55,1, 4'd3}, // R3 unpopped bypass stored
    '{1,0,8'h66, 0,0,1,0, 0,0,8'h00,1, 4'd7}, // R7 pop with nothing valid
    '{0,0,8'h00, 0,0,1,0, 1,0,8'h66,1, 4'd9}, // R9 shown next cycle
    '{1,0,8'h77, 1,0,0,1, 1,0,8'h77,1, 4'd7}, // R7 store pop on load bypass
    '{0,0,8'h00, 0,0,1,0, 1,0,8'h77,1, 4'd7}, // R7 request survived
    '{0,0,8'h00, 0,0,0,0, 0,0,8'h00,1, 4'd6}  // R6 empty again
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkRecord(input string tag, input logic [ADDR_W-1:0] a, input logic u);
    check({tag, " addr"}, 64'(outAddr), 64'(a));
    check({tag, " unit"}, 64'(outUnit), 64'(u));
    check({tag, " operand R3"}, 64'(outOperand), 64'({a, ~a}));
    check({tag, " byteEn R3"}, 64'(outByteEn), 64'(a[3:0]));
    check({tag, " opcode R3"}, 64'(outOpcode), 64'(a[3:0] ^ 4'h5));
    check({tag, " tag R3"}, 64'(outTag), 64'(a[2:0]));
  endtask

  task automatic drive(input logic v, input logic u, input logic [ADDR_W-1:0] a,
                       input logic lr, input logic sr, input logic lp, input logic sp);
    reqValid = v; reqUnit = u; reqAddr = a;
    loadReady = lr; storeReady = sr; loadPop = lp; storePop = sp;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outValid", 64'(outValid), 64'd0);
    check("R1 reset reqReady", 64'(reqReady), 64'd1);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].v, TBL[i].unit, ADDR_W'(TBL[i].addr),
            TBL[i].lr, TBL[i].sr, TBL[i].lp, TBL[i].sp);
      #1;
      begin
        string t;
        t = $sformatf("vec%0d R%0d", i, TBL[i].req);
        check({t, " outValid"}, 64'(outValid), 64'(TBL[i].expV));
        check({t, " reqReady"}, 64'(reqReady), 64'(TBL[i].expRdy));
        if (TBL[i].expV) checkRecord(t, ADDR_W'(TBL[i].expA), TBL[i].expU);
      end
    end

    // directed R4: fill both entries, then reset mid-run (R1)
    @(negedge clk); drive(1, 1, 16'h8181, 0, 0, 0, 0);
    @(negedge clk); drive(1, 1, 16'h8282, 0, 0, 0, 0);
    @(negedge clk); drive(0, 0, 16'h0, 0, 0, 0, 0);
    #1;
    check("R4 full reqReady", 64'(reqReady), 64'd0);
    checkRecord("R6 first in first out", 16'h8181, 1'b1);
    rstN = 1'b0;
    #1;
    check("R1 async reset outValid", 64'(outValid), 64'd0);
    check("R1 async reset reqReady", 64'(reqReady), 64'd1);
    @(negedge clk);
    rstN = 1'b1;

    // R2 after reset: full-width address pass-through to the load unit
    @(negedge clk); drive(1, 0, 16'hA5F0, 1, 0, 1, 0);
    #1;
    check("R2 after reset outValid", 64'(outValid), 64'd1);
    checkRecord("R2 after reset", 16'hA5F0, 1'b0);
    @(negedge clk); drive(0, 0, 16'h0, 0, 0, 0, 0);
    #1;
    check("R2 consumed, not stored", 64'(outValid), 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule